// File: doc/BRIEF.md
# Configurable PWM Channel Comparator

This block produces one pulse-width-modulated waveform and a counter-event pulse. It does this from a free-running period counter and a duty comparator. The counter runs in one of two modes:

- **Edge mode:** it counts up and wraps to zero.
- **Symmetric mode:** it counts up to the period value and then back down.

In both modes the waveform is formed by comparing the counter against the period minus the duty. The two boundary duty settings pin the output to a constant level. An event pulse marks the end of every period. In symmetric mode it can optionally also mark the peak.

The period, duty, polarity and mode inputs are captured while the channel is idle and frozen while it runs. Software therefore sets them up before raising the enable, and changes made during a run take effect only after the channel has been stopped. While idle, the waveform follows the polarity input with one register of delay.

Top module: `pwm_chan_cmp`

## Requirements
- R1: After reset, `wave_o` and `evt_pulse_o` are both 0.
- R2: While the channel is idle, the counter rests at zero and `evt_pulse_o` stays 0. One clock after `pol_sel` is sampled, `wave_o` equals it.
- R3: In edge mode (`ctr_sel`=0) with period value P≥1, the counter visits 0..P-1 and wraps. `evt_pulse_o` pulses once per P cycles, in the clock after the counter holds P-1.
- R4: In symmetric mode (`ctr_sel`=1) with P≥1, the counter rises to P and falls to 0, giving a 2P-cycle period. With `mid_sel`=0, exactly one event occurs per period, in the clock after the counter holds 0 on its falling ramp.
- R5: In symmetric mode with `mid_sel`=1, an extra event occurs in the clock after the counter holds P. Events are therefore spaced P cycles apart.
- R6: While running with 0 < D < P, `wave_o` equals the polarity level when the counter value c satisfies c ≥ P−D, and its inverse otherwise. The same compare applies on both ramps, and the output is registered one clock after the counter.
- R7: While running, D ≥ P fixes `wave_o` at the polarity level. D = 0 with P ≥ 1 fixes it at the inverse level. In particular, pol 0 with D = P gives constant 0, and pol 0 with D = 0 gives constant 1.
- R8: Period, duty, polarity and mode values are taken on the clock where `chan_en` is first seen high. Changes made while running have no effect on either output.
- R9: For P ≥ 2, every event is a single-cycle pulse.
- R10: A period value of 0 produces an event on every running cycle and a waveform fixed at the polarity level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel run enable |
| prd_val | input | W | Period value P |
| dty_val | input | W | Duty value D |
| pol_sel | input | 1 | Polarity level |
| ctr_sel | input | 1 | 0 = edge (up/wrap) mode, 1 = symmetric (up/down) mode |
| mid_sel | input | 1 | In symmetric mode, also raise an event at the peak |
| wave_o | output | 1 | Registered PWM waveform |
| evt_pulse_o | output | 1 | Registered counter-event pulse |

## Verification
The hardest condition to reach is an attempted reconfiguration during a run. The stimulus flips polarity, duty and mode in the middle of an active period, while the duty is pinned to a fixed-level setting. A frozen configuration then shows up as an unchanged constant output, whereas a leaking input would change it at once.

Symmetric mode with period values of 1 and 0 is also driven. These settings force the turn-around and wrap logic to act on consecutive cycles, and the spacing between successive event pulses is measured against P or 2P.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} cnt_dir_e;

  typedef struct packed {
    logic pol;
    logic ctr;
    logic mid;
  } chan_mode_t;
endpackage

// File: rtl/pwm_cfg_hold.sv
module pwm_cfg_hold
  import pwm_chan_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] prd_i,
  input  logic [W-1:0] dty_i,
  input  chan_mode_t   mode_i,
  output logic [W-1:0] prd_o,
  output logic [W-1:0] dty_o,
  output chan_mode_t   mode_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prd_o  <= '0;
      dty_o  <= '0;
      mode_o <= '0;
    end else if (!hold) begin
      prd_o  <= prd_i;
      dty_o  <= dty_i;
      mode_o <= mode_i;
    end
  end
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
  import pwm_chan_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] prd,
  input  logic         ctr_mode,
  input  logic         mid_en,
  output logic [W-1:0] cnt_o,
  output cnt_dir_e     dir_o,
  output logic         end_evt,
  output logic         mid_evt
);
  localparam int XW = W + 1;

  logic [XW-1:0] cnt_inc;
  logic          edge_wrap;
  logic          prd_zero;
  logic          at_peak;

  assign cnt_inc   = {1'b0, cnt_o} + XW'(1);
  assign edge_wrap = cnt_inc >= {1'b0, prd};
  assign prd_zero  = (prd == '0);
  assign at_peak   = (cnt_o == prd) && !prd_zero;

  always_comb begin
    if (!ctr_mode) begin
      end_evt = edge_wrap;
      mid_evt = 1'b0;
    end else begin
      end_evt = prd_zero || (dir_o == DIR_DN && cnt_o == '0);
      mid_evt = mid_en && dir_o == DIR_UP && at_peak;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_o <= '0;
      dir_o <= DIR_UP;
    end else if (!ctr_mode) begin
      dir_o <= DIR_UP;
      cnt_o <= edge_wrap ? '0 : cnt_inc[W-1:0];
    end else if (dir_o == DIR_UP) begin
      if (at_peak) begin
        dir_o <= DIR_DN;
        cnt_o <= cnt_o - W'(1);
      end else if (!prd_zero) begin
        cnt_o <= cnt_inc[W-1:0];
      end
    end else begin
      if (cnt_o == '0) begin
        dir_o <= DIR_UP;
        cnt_o <= W'(1);
      end else begin
        cnt_o <= cnt_o - W'(1);
      end
    end
  end
endmodule

// File: rtl/pwm_wave_cmp.sv
module pwm_wave_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] prd,
  input  logic [W-1:0] dty,
  input  logic         pol,
  output logic         lvl
);
  logic [W-1:0] thresh;
  logic         at_pol;

  assign thresh = prd - dty;
  always_comb begin
    if (dty >= prd)       at_pol = 1'b1;
    else if (dty == '0)   at_pol = 1'b0;
    else                  at_pol = (cnt >= thresh);
    lvl = at_pol ? pol : ~pol;
  end
endmodule

// File: rtl/pwm_chan_cmp.sv
module pwm_chan_cmp
  import pwm_chan_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         chan_en,
  input  logic [W-1:0] prd_val,
  input  logic [W-1:0] dty_val,
  input  logic         pol_sel,
  input  logic         ctr_sel,
  input  logic         mid_sel,
  output logic         wave_o,
  output logic         evt_pulse_o
);
  logic         run_q;
  logic [W-1:0] prd_q;
  logic [W-1:0] dty_q;
  chan_mode_t   mode_in;
  chan_mode_t   mode_q;
  logic [W-1:0] cnt_q;
  cnt_dir_e     dir_q;
  logic         end_evt;
  logic         mid_evt;
  logic         cmp_lvl;

  assign mode_in = '{pol: pol_sel, ctr: ctr_sel, mid: mid_sel};

  pwm_cfg_hold #(.W(W)) cfg_i (
    .clk(clk), .rst(rst), .hold(run_q),
    .prd_i(prd_val), .dty_i(dty_val), .mode_i(mode_in),
    .prd_o(prd_q), .dty_o(dty_q), .mode_o(mode_q)
  );

  pwm_period_ctr #(.W(W)) ctr_i (
    .clk(clk), .rst(rst), .run(run_q), .prd(prd_q),
    .ctr_mode(mode_q.ctr), .mid_en(mode_q.mid),
    .cnt_o(cnt_q), .dir_o(dir_q), .end_evt(end_evt), .mid_evt(mid_evt)
  );

  pwm_wave_cmp #(.W(W)) cmp_i (
    .cnt(cnt_q), .prd(prd_q), .dty(dty_q), .pol(mode_q.pol), .lvl(cmp_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= 1'b0;
      wave_o      <= 1'b0;
      evt_pulse_o <= 1'b0;
    end else begin
      run_q       <= chan_en;
      wave_o      <= run_q ? cmp_lvl : pol_sel;
      evt_pulse_o <= run_q && (end_evt || mid_evt);
    end
  end
endmodule

// File: rtl/pwm_chan_cmp_chk.sv
module pwm_chan_cmp_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         run_q,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] prd_q,
  input logic [W-1:0] dty_q,
  input logic         pol_q,
  input logic         ctr_q,
  input logic         wave_o,
  input logic         evt_pulse_o
);
  // R2
  idle_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !evt_pulse_o);

  // R2
  idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> cnt_q == '0);

  // R3
  edge_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !ctr_q) |=> (cnt_q == '0 || cnt_q == $past(cnt_q) + W'(1)));

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> cnt_q <= prd_q);

  // R7
  fixed_pol_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && dty_q >= prd_q) |=> wave_o == $past(pol_q));

  // R7
  fixed_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && dty_q == '0 && prd_q != '0) |=> wave_o == !$past(pol_q));

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q)) |-> ($stable(prd_q) && $stable(dty_q) && $stable(pol_q)));
endmodule

bind pwm_chan_cmp pwm_chan_cmp_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .run_q(run_q), .cnt_q(cnt_q), .prd_q(prd_q),
  .dty_q(dty_q), .pol_q(mode_q.pol), .ctr_q(mode_q.ctr),
  .wave_o(wave_o), .evt_pulse_o(evt_pulse_o)
);

// File: tb/pwm_chan_cmp_tb_top.sv
module pwm_chan_cmp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         chan_en = 1'b0;
  logic [W-1:0] prd_val = '0;
  logic [W-1:0] dty_val = '0;
  logic         pol_sel = 1'b0;
  logic         ctr_sel = 1'b0;
  logic         mid_sel = 1'b0;
  logic         wave_o;
  logic         evt_pulse_o;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  int cyc = 0;
  int gap_exp = 0;
  int last_evt = -1;
  logic prev_evt = 1'b0;
  bit done = 0;

  // reference model state
  int m_run = 0, m_cnt = 0, m_down = 0;
  int m_p = 0, m_d = 0, m_pol = 0, m_ctr = 0, m_mid = 0;
  int e_wave = 0, e_evt = 0;

  pwm_chan_cmp #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .chan_en(chan_en), .prd_val(prd_val),
    .dty_val(dty_val), .pol_sel(pol_sel), .ctr_sel(ctr_sel),
    .mid_sel(mid_sel), .wave_o(wave_o), .evt_pulse_o(evt_pulse_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_level(int c);
    int on_pol;
    if (m_d >= m_p) on_pol = 1;
    else if (m_d == 0) on_pol = 0;
    else on_pol = (c + m_d >= m_p) ? 1 : 0;
    return on_pol ? m_pol : 1 - m_pol;
  endfunction

  always @(posedge clk) begin
    int n_wave, n_evt, ev;
    cyc = cyc + 1;
    if (rst) begin
      m_run = 0; m_cnt = 0; m_down = 0; m_p = 0; m_d = 0;
      m_pol = 0; m_ctr = 0; m_mid = 0; e_wave = 0; e_evt = 0;
    end else begin
      n_wave = m_run ? ref_level(m_cnt) : int'(pol_sel);
      ev = 0;
      if (m_run) begin
        if (m_ctr == 0) ev = (m_cnt + 1 >= m_p);
        else if (m_p == 0) ev = 1;
        else if (m_down && m_cnt == 0) ev = 1;
        else if (!m_down && m_cnt == m_p && m_mid) ev = 1;
      end
      n_evt = ev;
      if (!m_run) begin
        m_cnt = 0; m_down = 0;
      end else if (m_ctr == 0) begin
        m_cnt = (m_cnt + 1 >= m_p) ? 0 : m_cnt + 1;
      end else if (m_p != 0) begin
        if (!m_down) begin
          if (m_cnt == m_p) begin m_down = 1; m_cnt = m_cnt - 1; end
          else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_down = 0; m_cnt = 1; end
          else m_cnt = m_cnt - 1;
        end
      end
      if (!m_run) begin
        m_p = int'(prd_val); m_d = int'(dty_val); m_pol = int'(pol_sel);
        m_ctr = int'(ctr_sel); m_mid = int'(mid_sel);
      end
      m_run = int'(chan_en);
      e_wave = n_wave; e_evt = n_evt;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison and event spacing, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({cur_tag, " wave"}, int'(wave_o), e_wave);
      chk({cur_tag, " evt"}, int'(evt_pulse_o), e_evt);
      if (evt_pulse_o) begin
        if (gap_exp >= 2) chk("R9 single pulse", int'(prev_evt), 0);
        if (gap_exp != 0 && last_evt >= 0)
          chk({cur_tag, " event gap"}, cyc - last_evt, gap_exp);
        last_evt = cyc;
      end
      prev_evt = evt_pulse_o;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_phase(input string tag, input int p, input int d,
                           input bit pol, input bit ctr, input bit mid,
                           input int len, input int gap);
    @(negedge clk);
    cur_tag = tag; gap_exp = gap; last_evt = -1;
    prd_val = W'(p); dty_val = W'(d); pol_sel = pol; ctr_sel = ctr; mid_sel = mid;
    chan_en = 1'b1;
    wait_cyc(len);
    chan_en = 1'b0;
    gap_exp = 0;
    wait_cyc(4);
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 wave", int'(wave_o), 0);
    chk("R1 evt", int'(evt_pulse_o), 0);

    // R2 idle: output follows polarity
    cur_tag = "R2";
    pol_sel = 1'b1; @(negedge clk);
    chk("R2 idle pol high", int'(wave_o), 1);
    pol_sel = 1'b0; @(negedge clk);
    chk("R2 idle pol low", int'(wave_o), 0);
    chk("R2 idle evt", int'(evt_pulse_o), 0);

    run_phase("R3", 5, 2, 1'b0, 1'b0, 1'b0, 40, 5);
    run_phase("R3", 1, 0, 1'b1, 1'b0, 1'b0, 10, 1);
    run_phase("R6", 8, 3, 1'b1, 1'b0, 1'b0, 40, 8);
    run_phase("R4", 4, 2, 1'b0, 1'b1, 1'b0, 50, 8);
    run_phase("R6", 6, 5, 1'b1, 1'b1, 1'b0, 50, 12);
    run_phase("R5", 4, 1, 1'b0, 1'b1, 1'b1, 50, 4);
    run_phase("R5", 1, 1, 1'b1, 1'b1, 1'b1, 12, 1);
    run_phase("R7", 6, 6, 1'b0, 1'b0, 1'b0, 30, 6);
    run_phase("R7", 6, 0, 1'b0, 1'b1, 1'b0, 30, 12);
    run_phase("R7", 5, 0, 1'b1, 1'b0, 1'b0, 20, 5);
    run_phase("R7", 5, 9, 1'b1, 1'b1, 1'b0, 20, 10);
    run_phase("R10", 0, 0, 1'b1, 1'b0, 1'b0, 10, 1);
    run_phase("R10", 0, 3, 1'b0, 1'b1, 1'b1, 10, 1);

    // R8 reconfiguration during a run is ignored
    @(negedge clk);
    cur_tag = "R8"; gap_exp = 0; last_evt = -1;
    prd_val = 16'd6; dty_val = 16'd6; pol_sel = 1'b1; ctr_sel = 1'b0; mid_sel = 1'b0;
    chan_en = 1'b1;
    wait_cyc(9);
    pol_sel = 1'b0; dty_val = 16'd0; prd_val = 16'd2; ctr_sel = 1'b1;
    wait_cyc(2);
    chk("R8 frozen level", int'(wave_o), 1);
    wait_cyc(20);
    chk("R8 frozen level late", int'(wave_o), 1);
    chan_en = 1'b0;
    wait_cyc(2);
    chk("R8 idle follows new pol", int'(wave_o), 0);
    wait_cyc(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule